// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block predicts whether a conditional branch is taken. It holds a table of small saturating counters. Each row of the table belongs to a group of branch addresses, and each row has one counter for every value of a shared outcome history. The history records what the most recent resolved branches did, whatever their addresses. A lookup takes the low address bits of the branch to pick a row, then uses the current history to pick a counter in that row. The most significant bit of that counter is the prediction. Because the history selects the counter, a branch whose outcome follows from its neighbours' outcomes can be predicted correctly. A predictor keyed only on the branch's own address cannot do this.

The fetch side presents a PC on the lookup port and reads back a taken or not-taken bit in the same cycle. The resolve side reports a PC and its real outcome on the update port. That update moves the counter the history currently points to one step towards the outcome. It then shifts the outcome into the history. `HIST_BITS` (m), `CTR_BITS` (n) and `ROW_BITS` set the shape of the table. The table holds 2^m × n × 2^ROW_BITS bits.

Top module: `gh_corr_predictor`

## Requirements
- R1: After reset the history is all zeros. Every counter holds its weakly-not-taken value, which is 01 for n=2 and 0 for n=1. So every PC is predicted not taken.
- R2: The prediction is the most significant bit of the selected counter. For n=2, values 10 and 11 give taken and values 00 and 01 give not taken.
- R3: The row is `pc[ROW_BITS-1:0]`. PCs that differ only in the bits above those select the same counters.
- R4: Within a row, the counter used is the one whose column number equals the current history value. The flat table index is `{row, history}`.
- R5: An update with `upd_valid` high shifts the history left by one bit and puts the outcome in bit 0 (1 = taken). The new history is used from the next cycle on.
- R6: An update increments the selected counter on taken and decrements it on not taken. The counter holds at its all-ones maximum and at zero.
- R7: With n=2, a counter at its strongly-taken value keeps predicting taken after one not-taken update. It flips to not taken after a second not-taken update.
- R8: Lookup is combinational. When an update and a lookup of the same counter occur in the same cycle, the lookup returns the value from before the update.
- R9: With `upd_valid` low, the update port is ignored. The counters and the history stay unchanged.
- R10: With m=1 and n=1 starting from reset, take two branches at different rows that each resolve taken and not taken on alternate passes. Only the first pass is mispredicted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| look_pc | input | PC_BITS | Address of the branch to predict |
| look_taken | output | 1 | Prediction for `look_pc`: 1 = taken |
| upd_valid | input | 1 | Update strobe for the resolve side |
| upd_pc | input | PC_BITS | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome: 1 = taken |

## Verification
A prediction belongs to the cycle in which its PC is presented, because lookup has no register on the path. An update becomes visible one rising edge later, in both the counter and the history. The driver changes inputs on the falling edge. At that moment it pushes the expected prediction into the scoreboard, computed from a bench-side model whose state still excludes this cycle's update. The monitor pops that entry two nanoseconds later, well before the next rising edge, so a same-cycle update can never leak into the sample. The single-bit instance for R10 is checked at the same point in each cycle.

// File: rtl/gh_corr_predictor.sv
module gh_corr_predictor #(
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  parameter int ROW_BITS  = 4,
  parameter int PC_BITS   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_BITS-1:0] look_pc,
  output logic               look_taken,
  input  logic               upd_valid,
  input  logic [PC_BITS-1:0] upd_pc,
  input  logic               upd_taken
);

  localparam int IDX_W   = ROW_BITS + HIST_BITS;
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CTR_BITS-1:0] CTR_MAX  = '1;
  localparam logic [CTR_BITS-1:0] CTR_INIT = CTR_MAX >> 1;

  logic [CTR_BITS-1:0]  tbl [ENTRIES];
  logic [HIST_BITS-1:0] hist;
  logic [HIST_BITS:0]   hist_shift;
  logic [IDX_W-1:0]     look_idx, upd_idx;
  logic [CTR_BITS-1:0]  look_ctr, upd_cur, upd_nxt;
  logic                 unused_pc_hi;

  assign look_idx   = {look_pc[ROW_BITS-1:0], hist};
  assign upd_idx    = {upd_pc[ROW_BITS-1:0], hist};
  assign look_ctr   = tbl[look_idx];
  assign upd_cur    = tbl[upd_idx];
  assign look_taken = look_ctr[CTR_BITS-1];
  assign hist_shift = {hist, upd_taken};
  assign unused_pc_hi = ^{look_pc[PC_BITS-1:ROW_BITS], upd_pc[PC_BITS-1:ROW_BITS]};

  always_comb begin
    upd_nxt = upd_cur;
    if (upd_taken && upd_cur != CTR_MAX)
      upd_nxt = upd_cur + CTR_BITS'(1);
    else if (!upd_taken && upd_cur != '0)
      upd_nxt = upd_cur - CTR_BITS'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_INIT;
    end else if (upd_valid) begin
      hist         <= hist_shift[HIST_BITS-1:0];
      tbl[upd_idx] <= upd_nxt;
    end
  end

  // R1: history leaves reset cleared
  p_reset_hist_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> hist == '0);

  // R5: newest outcome lands in bit 0
  p_hist_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> hist[0] == $past(upd_taken));

  generate
    if (HIST_BITS > 1) begin : g_hist_hi
      p_hist_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist[HIST_BITS-1:1] == $past(hist[HIST_BITS-2:0]));
    end
  endgenerate

  // R9: idle update port leaves history alone
  p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hist));

  // R6: counters hold at both ends
  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_taken && upd_cur == CTR_MAX |=> tbl[$past(upd_idx)] == CTR_MAX);
  p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_taken && upd_cur == '0 |=> tbl[$past(upd_idx)] == '0);

  // R8: prediction only moves with the PC or after an update edge
  p_look_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(look_pc) && !$past(upd_valid) |-> $stable(look_taken));

endmodule

// File: tb/test_gh_corr_predictor.sv
module test_gh_corr_predictor;
  localparam int M = 2, N = 2, RB = 4, PW = 16;
  localparam int COLS = 1 << M;
  localparam int ENTS = (1 << RB) * COLS;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0;

  logic [PW-1:0] look_pc = '0, upd_pc = '0;
  logic look_taken, upd_valid = 1'b0, upd_taken = 1'b0;
  logic [PW-1:0] s_look_pc = '0, s_upd_pc = '0;
  logic s_look_taken, s_upd_valid = 1'b0, s_upd_taken = 1'b0;

  gh_corr_predictor #(.HIST_BITS(M), .CTR_BITS(N), .ROW_BITS(RB), .PC_BITS(PW)) i_gh_corr_predictor (
    .clk(clk), .rst_n(rst_n), .look_pc(look_pc), .look_taken(look_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  gh_corr_predictor #(.HIST_BITS(1), .CTR_BITS(1), .ROW_BITS(2), .PC_BITS(PW)) i_gh_corr_predictor_small (
    .clk(clk), .rst_n(rst_n), .look_pc(s_look_pc), .look_taken(s_look_taken),
    .upd_valid(s_upd_valid), .upd_pc(s_upd_pc), .upd_taken(s_upd_taken));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { bit exp; string req; } item_t;
  item_t sbq[$];

  int ref_ctr [ENTS];
  int ref_hist = 0;

  function automatic bit ref_pred(logic [PW-1:0] pc);
    return ref_ctr[int'(pc[RB-1:0]) * COLS + ref_hist] >= 2;
  endfunction

  function automatic void ref_update(logic [PW-1:0] pc, bit t);
    int idx;
    idx = int'(pc[RB-1:0]) * COLS + ref_hist;
    if (t && ref_ctr[idx] < 3) ref_ctr[idx]++;
    else if (!t && ref_ctr[idx] > 0) ref_ctr[idx]--;
    ref_hist = ((ref_hist << 1) | int'(t)) & (COLS - 1);
  endfunction

  // driver: model expectation (pre-update) or literal expectation
  task automatic step(logic [PW-1:0] pc, bit uv, logic [PW-1:0] upc, bit ut,
                      bit use_lit, bit lit, string req);
    item_t it;
    @(negedge clk);
    look_pc = pc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    it.exp = use_lit ? lit : ref_pred(pc);
    it.req = req;
    sbq.push_back(it);
    if (uv) ref_update(upc, ut);
  endtask

  task automatic upd(logic [PW-1:0] pc, bit t, string req);
    step(pc, 1'b1, pc, t, 1'b0, 1'b0, req);
  endtask

  task automatic look(logic [PW-1:0] pc, bit lit, string req);
    step(pc, 1'b0, '0, 1'b0, 1'b1, lit, req);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (look_taken !== it.exp) begin
          errors++;
          $display("FAIL %s pc=%h actual=%b expected=%b", it.req, look_pc, look_taken, it.exp);
        end
      end
    end
  end

  task automatic s_step(logic [PW-1:0] pc, bit t, bit exp, string req);
    @(negedge clk);
    s_look_pc = pc; s_upd_valid = 1'b1; s_upd_pc = pc; s_upd_taken = t;
    #2;
    checks++;
    if (s_look_taken !== exp) begin
      errors++;
      $display("FAIL %s pc=%h actual=%b expected=%b", req, pc, s_look_taken, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int s_miss;
    for (int i = 0; i < ENTS; i++) ref_ctr[i] = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: everything weakly not taken
    look(16'h0000, 1'b0, "R1");
    look(16'h0005, 1'b0, "R1");
    look(16'h000F, 1'b0, "R1");
    look(16'hABCD, 1'b0, "R1");

    // R7: train row 3 up to strong taken, then two misses
    repeat (4) upd(16'h0003, 1'b1, "R4");
    upd(16'h0003, 1'b0, "R7");
    upd(16'h0005, 1'b1, "R5");
    upd(16'h0005, 1'b1, "R5");
    look(16'h0003, 1'b1, "R7 one miss keeps taken");
    upd(16'h0003, 1'b0, "R7");
    upd(16'h0005, 1'b1, "R5");
    upd(16'h0005, 1'b1, "R5");
    look(16'h0003, 1'b0, "R7 second miss flips");

    // R3: upper PC bits alias onto the same row
    look(16'h0FF3, 1'b0, "R3");
    upd(16'h0007, 1'b0, "R5");
    upd(16'h0007, 1'b1, "R5");
    // R4: history now 01, row 3 column 01 still taken
    look(16'h0003, 1'b1, "R4");
    look(16'h0F05, 1'b1, "R3");
    look(16'h0004, 1'b0, "R3");

    // R8: same-cycle lookup and update of one counter
    step(16'h0003, 1'b1, 16'h0003, 1'b0, 1'b1, 1'b1, "R8");
    look(16'h0003, 1'b0, "R8");

    // R9: ignored taken update on row 7 while history is 10
    step(16'h0001, 1'b0, 16'h0007, 1'b1, 1'b0, 1'b0, "R9");
    look(16'h0007, 1'b1, "R9");

    // R6: saturation at top and bottom
    repeat (6) upd(16'h0009, 1'b1, "R6");
    upd(16'h0009, 1'b0, "R6");
    upd(16'h000A, 1'b1, "R6");
    upd(16'h000A, 1'b1, "R6");
    look(16'h0009, 1'b1, "R6 top holds");
    repeat (2) upd(16'h000C, 1'b0, "R6");
    repeat (2) upd(16'h000C, 1'b1, "R6");
    repeat (2) upd(16'h000D, 1'b0, "R6");
    upd(16'h000C, 1'b0, "R6");

    // R2/R5 mixed traffic against the model
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [PW-1:0] p;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p = {lfsr[15:8], 4'h0, lfsr[3:0]};
      step(p, lfsr[5] | lfsr[6], {lfsr[11:4], 4'h0, lfsr[3:0]} ^ 16'h0003,
           lfsr[7] ^ lfsr[9], 1'b0, 1'b0, "R2 R5 R9");
    end
    @(negedge clk);
    upd_valid = 1'b0;

    // R10: alternating pair on m=1 n=1 instance
    s_miss = 0;
    for (int pass = 0; pass < 8; pass++) begin
      bit act;
      act = (pass % 2) == 0;
      s_step(16'h0000, act, (pass == 0) ? 1'b0 : act, "R10 b1");
      s_step(16'h0001, act, (pass == 0) ? 1'b0 : act, "R10 b2");
    end
    @(negedge clk);
    s_upd_valid = 1'b0;

    repeat (3) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard-drain actual=%0d expected=0", sbq.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule